// File: doc/BRIEF.md
# GPIO Port Edge-Interrupt Controller

This block is an eight-pin general-purpose I/O port. Each pin has a four-bit operating mode. The mode is made of one bit from each of four byte-wide control registers: data, direction, alternate and an extra control register. Two of the sixteen mode values turn the pin into an edge-interrupt source. Mode 6 reacts to falling edges and mode 9 reacts to both edges. Every pin input is synchronised before its edge detector. A qualifying edge latches a per-pin pending flag, and the flags are OR-ed into a single port interrupt request.

Software acknowledges a pin's interrupt by writing a 1 into that pin's bit of the data register. While a pin is in an edge-interrupt mode, its stored data bit is locked against bus writes. The acknowledge therefore cannot disturb the mode, which itself depends on that data bit. Acknowledge and lock are decided per pin from that pin's own configuration only, so no pin can clear or protect another. This holds in particular for the mirror pairs 0/7, 1/6, 2/5 and 3/4. Pins that are not in an edge mode stay fully usable for any other purpose.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every pin is in input mode: the data, alternate and control registers read 0x00 and the direction register reads 0xFF. No pin is pending, `irq` is 0 and `pin_oe` is 0x00.
- R2: A write with `wr_addr` 0, 1, 2 or 3 loads the data, direction, alternate or control register, and `rd_addr` with the same code reads it back. `rd_addr` 4 reads the pending flags. Writes to addresses 4 to 7 change nothing.
- R3: In mode 6 a falling edge on a pin sets that pin's pending flag, and a rising edge does not. The flag is readable after the third rising clock edge following the input change. The mode of pin i is {control[i], alternate[i], direction[i], data[i]} read as a number.
- R4: In mode 9, both a rising and a falling edge set the pin's pending flag.
- R5: In any mode other than 6 or 9, no input transition sets a pending flag.
- R6: In mode 6 or 9, a data-register write with a 1 in bit i clears pin i's flag on that clock edge. A 0 in bit i leaves the flag unchanged.
- R7: While pin i is in mode 6 or 9, data-register writes never change data bit i, whatever value is written.
- R8: A clear or data write aimed at one pin has no effect on any other pin's flag or data lock, its mirror pin 7-i included. A mirror pin in a non-edge mode still takes data writes normally.
- R9: If a qualifying edge and a clearing write reach a pin on the same clock edge, the flag ends up set.
- R10: `irq` is 1 exactly when the pending-flag register (address 4) is non-zero.
- R11: A pin that leaves modes 6 and 9 has its pending flag dropped on the following clock edge.
- R12: `pin_out` always equals the data register. `pin_oe[i]` is 1 only in modes 0 and 1 (control, alternate and direction bits all 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_addr | input | 3 | Register select for reads |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Port interrupt request |

## Verification
Edge detection and the software acknowledge can land on the same clock edge for one pin, and the design must then keep the flag. The bench provokes this by changing a pin input and then holding a clearing data write exactly on the third rising edge after the change. That is the edge on which the synchronised sample and the previous sample first differ. This is done for a falling-edge pin whose flag was clear and for a dual-edge pin whose flag was already set. The result is judged by reading the pending register afterwards: the bit must still be 1, and a later ordinary acknowledge must clear it.

// File: rtl/gpio_edge_pkg.sv
// Package: shared constants for the edge-interrupt GPIO port.
// Assumes a 3-bit register address space and a 4-bit per-pin mode.
package gpio_edge_pkg;
    localparam int ADDR_W = 3;
    localparam int MODE_W = 4;

    // Register select codes for the bus interface.
    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_ALT  = 3'd2,
        REG_CTL  = 3'd3,
        REG_PEND = 3'd4
    } reg_sel_e;

    // Mode values; mode = {ctl, alt, dir, data}.
    localparam logic [MODE_W-1:0] MODE_EDGE_FALL = 4'd6;
    localparam logic [MODE_W-1:0] MODE_EDGE_BOTH = 4'd9;
    localparam logic [MODE_W-1:0] MODE_INPUT     = 4'd2;
endpackage

// File: rtl/gpio_edge_sync.sv
// Module: multi-stage synchroniser for a bus of asynchronous inputs.
// Assumes STAGES >= 2; each bit is synchronised independently.
module gpio_edge_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
// Module: one GPIO pin: its four control bits, edge detector and
// pending flag. Assumes pin_s is already synchronised to clk.
// All decisions use only this pin's own bits, so pins never couple.
module gpio_edge_cell
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_bit,
    input  logic wr_dat,
    input  logic wr_dir,
    input  logic wr_alt,
    input  logic wr_ctl,
    input  logic pin_s,
    output logic dat_q,
    output logic dir_q,
    output logic alt_q,
    output logic ctl_q,
    output logic pend_q,
    output logic hit,
    output logic drv_oe
);
    logic [MODE_W-1:0] mode;
    logic edge_en;
    logic prev_q;
    logic rose;
    logic fell;
    logic ack;

    // Decode this pin's mode from its four control bits.
    always_comb begin
        mode    = {ctl_q, alt_q, dir_q, dat_q};
        edge_en = (mode == MODE_EDGE_FALL) || (mode == MODE_EDGE_BOTH);
        rose    = pin_s & ~prev_q;
        fell    = ~pin_s & prev_q;
        hit     = ((mode == MODE_EDGE_FALL) & fell) |
                  ((mode == MODE_EDGE_BOTH) & (fell | rose));
        ack     = wr_dat & wr_bit & edge_en;
        drv_oe  = ~ctl_q & ~alt_q & ~dir_q;
    end

    // Control bits; the data bit is locked while in an edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= MODE_INPUT[0];
            dir_q <= MODE_INPUT[1];
            alt_q <= MODE_INPUT[2];
            ctl_q <= MODE_INPUT[3];
        end else begin
            if (wr_dat && !edge_en) dat_q <= wr_bit;
            if (wr_dir) dir_q <= wr_bit;
            if (wr_alt) alt_q <= wr_bit;
            if (wr_ctl) ctl_q <= wr_bit;
        end
    end

    // Previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Pending flag: dropped outside edge modes, set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (!edge_en) pend_q <= 1'b0;
        else if (hit)      pend_q <= 1'b1;
        else if (ack)      pend_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the edge-interrupt GPIO port. Decodes register
// writes into per-pin strobes, instantiates one cell per pin, muxes
// reads and ORs the pending flags into irq. Assumes a single write
// per cycle and combinational reads.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] dr_q;
    logic [NPINS-1:0] ddr_q;
    logic [NPINS-1:0] alt_q;
    logic [NPINS-1:0] ctl_q;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] hit_w;
    logic [NPINS-1:0] oe_w;
    logic wr_dat;
    logic wr_dir;
    logic wr_alt;
    logic wr_ctl;

    gpio_edge_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    // Turn a bus write into one strobe per control register.
    always_comb begin
        wr_dat = wr_en && (wr_addr == REG_DATA);
        wr_dir = wr_en && (wr_addr == REG_DIR);
        wr_alt = wr_en && (wr_addr == REG_ALT);
        wr_ctl = wr_en && (wr_addr == REG_CTL);
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_edge_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_bit (wr_data[i]),
            .wr_dat (wr_dat),
            .wr_dir (wr_dir),
            .wr_alt (wr_alt),
            .wr_ctl (wr_ctl),
            .pin_s  (pin_s[i]),
            .dat_q  (dr_q[i]),
            .dir_q  (ddr_q[i]),
            .alt_q  (alt_q[i]),
            .ctl_q  (ctl_q[i]),
            .pend_q (pend_q[i]),
            .hit    (hit_w[i]),
            .drv_oe (oe_w[i])
        );
    end

    // Select the register named by rd_addr.
    always_comb begin
        case (rd_addr)
            REG_DATA: rd_data = dr_q;
            REG_DIR:  rd_data = ddr_q;
            REG_ALT:  rd_data = alt_q;
            REG_CTL:  rd_data = ctl_q;
            REG_PEND: rd_data = pend_q;
            default:  rd_data = '0;
        endcase
    end

    assign pin_out = dr_q;
    assign pin_oe  = oe_w;
    assign irq     = |pend_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
// Module: assertion checker for gpio_edge_port, attached by bind.
// Recomputes the edge-mode mask from the control bits on its own.
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NPINS-1:0]  wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [NPINS-1:0]  rd_data,
    input logic              irq,
    input logic [NPINS-1:0]  dr,
    input logic [NPINS-1:0]  ddr,
    input logic [NPINS-1:0]  alt,
    input logic [NPINS-1:0]  ctl,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  hit
);
    logic [NPINS-1:0] em;
    logic data_wr;

    // Per-pin edge-mode mask from the raw control bits.
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            em[i] = ({ctl[i], alt[i], ddr[i], dr[i]} == 4'd6) ||
                    ({ctl[i], alt[i], ddr[i], dr[i]} == 4'd9);
        end
        data_wr = wr_en && (wr_addr == REG_DATA);
    end

    AST_ACK_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (((dr ^ $past(dr)) & $past(em)) == '0)); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> ((pend & $past(wr_data & em & ~hit)) == '0)); // R6

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(hit)) == $past(hit))); // R9

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R5

    AST_DROP_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(em)) == '0)); // R11

    AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_PEND) |-> (irq == (rd_data != '0))); // R10
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .dr      (dr_q),
    .ddr     (ddr_q),
    .alt     (alt_q),
    .ctl     (ctl_q),
    .pend    (pend_q),
    .hit     (hit_w)
);

// File: tb/test_gpio_edge_port.sv
// Bench: sweeps every mode on every pin, then targets pin independence,
// edge/acknowledge collisions and mode exit.
module test_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] sh_dr = 8'h00;
    logic [7:0] sh_dir = 8'hFF;
    logic [7:0] sh_alt = 8'h00;
    logic [7:0] sh_ctl = 8'h00;

    always #10 clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Move pin i to mode m through a path that never locks the data bit.
    task automatic set_mode(input int i, input logic [3:0] m);
        sh_ctl[i] = 1'b0; wr(3'd3, sh_ctl);
        sh_alt[i] = 1'b0; wr(3'd2, sh_alt);
        sh_dir[i] = m[1]; wr(3'd1, sh_dir);
        sh_dr[i]  = m[0]; wr(3'd0, sh_dr);
        sh_alt[i] = m[2]; wr(3'd2, sh_alt);
        sh_ctl[i] = m[3]; wr(3'd3, sh_ctl);
    endtask

    initial begin : watchdog
        #3000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] exp_p;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(3'd0, v); chk("R1 data", v, 8'h00);
        rd(3'd1, v); chk("R1 dir", v, 8'hFF);
        rd(3'd2, v); chk("R1 alt", v, 8'h00);
        rd(3'd3, v); chk("R1 ctl", v, 8'h00);
        rd(3'd4, v); chk("R1 pend", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 oe", pin_oe, 8'h00);

        // R2 unused addresses ignored, R12 output enable
        wr(3'd5, 8'hFF); wr(3'd7, 8'hFF); wr(3'd4, 8'hFF);
        rd(3'd0, v); chk("R2 data after bad write", v, 8'h00);
        rd(3'd1, v); chk("R2 dir after bad write", v, 8'hFF);
        rd(3'd2, v); chk("R2 alt after bad write", v, 8'h00);
        rd(3'd3, v); chk("R2 ctl after bad write", v, 8'h00);
        rd(3'd4, v); chk("R2 pend after bad write", v, 8'h00);
        wr(3'd1, 8'hA5);
        rd(3'd1, v); chk("R2 dir readback", v, 8'hA5);
        chk("R12 oe from dir", pin_oe, 8'h5A);
        wr(3'd1, 8'hFF);

        // Sweep every mode on every pin
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 16; m++) begin
                logic [3:0] mv;
                logic [7:0] bm;
                logic edge_m;
                mv = 4'(m);
                bm = 8'(1) << i;
                edge_m = (mv == 4'd6) || (mv == 4'd9);
                set_mode(i, mv);
                chk("R12 oe", pin_oe, (mv < 4'd2) ? bm : 8'h00);
                chk("R12 pin_out", pin_out, sh_dr);
                pin_in[i] = 1'b1;
                wait_cyc(4);
                rd(3'd4, v);
                chk("R4 R5 R3 rise", v, (mv == 4'd9) ? bm : 8'h00);
                chk("R10 irq rise", irq, (mv == 4'd9));
                if (mv == 4'd9) begin
                    wr(3'd0, sh_dr | bm);
                    rd(3'd4, v); chk("R6 clear after rise", v, 8'h00);
                end
                pin_in[i] = 1'b0;
                wait_cyc(4);
                rd(3'd4, v);
                chk("R3 R4 R5 fall", v, edge_m ? bm : 8'h00);
                chk("R10 irq fall", irq, edge_m);
                if (edge_m) begin
                    wr(3'd0, sh_dr ^ bm);
                    rd(3'd0, v); chk("R7 data locked", v, sh_dr);
                    rd(3'd4, v); chk("R6 bit value", v, (mv == 4'd9) ? bm : 8'h00);
                    wr(3'd0, sh_dr | bm);
                    rd(3'd0, v); chk("R7 data locked on ack", v, sh_dr);
                    rd(3'd4, v); chk("R6 ack clears", v, 8'h00);
                    chk("R10 irq after ack", irq, 0);
                end
                set_mode(i, 4'd2);
            end
        end

        // R8 independence: all pins falling-edge, clear one at a time
        for (int i = 0; i < 8; i++) set_mode(i, 4'd6);
        pin_in = 8'hFF; wait_cyc(4);
        pin_in = 8'h00; wait_cyc(4);
        rd(3'd4, v); chk("R8 all pending", v, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, 8'(1) << i);
            exp_p = 8'(8'hFF << (i + 1));
            rd(3'd4, v); chk("R8 single clear", v, exp_p);
            rd(3'd0, v); chk("R8 R7 data held", v, 8'h00);
        end
        for (int i = 0; i < 8; i++) set_mode(i, 4'd2);

        // R8 mirror pin 7 in input mode while pin 0 is edge
        set_mode(0, 4'd6);
        pin_in[0] = 1'b1; wait_cyc(4);
        pin_in[0] = 1'b0; wait_cyc(4);
        wr(3'd0, 8'h80); sh_dr = 8'h80;
        rd(3'd4, v); chk("R8 mirror write keeps pin0 flag", v, 8'h01);
        rd(3'd0, v); chk("R8 mirror data written", v, 8'h80);
        wr(3'd0, 8'h81);
        rd(3'd4, v); chk("R8 pin0 own clear", v, 8'h00);
        rd(3'd0, v); chk("R8 data after own clear", v, 8'h80);
        wr(3'd0, 8'h00); sh_dr = 8'h00;
        rd(3'd0, v); chk("R8 mirror data restored", v, 8'h00);
        set_mode(0, 4'd2);

        // R9 collision on a dual-edge pin with flag already set
        set_mode(4, 4'd9);
        pin_in[4] = 1'b1; wait_cyc(4);
        rd(3'd4, v); chk("R4 set before collision", v, 8'h10);
        pin_in[4] = 1'b0;
        wait_cyc(2);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = sh_dr | 8'h10;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd4, v); chk("R9 dual-edge collision", v, 8'h10);
        wr(3'd0, sh_dr | 8'h10);
        rd(3'd4, v); chk("R9 later ack clears", v, 8'h00);
        set_mode(4, 4'd2);

        // R9 collision on a falling-edge pin with flag clear
        set_mode(2, 4'd6);
        pin_in[2] = 1'b1; wait_cyc(4);
        pin_in[2] = 1'b0;
        wait_cyc(2);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = sh_dr | 8'h04;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd4, v); chk("R9 fall collision", v, 8'h04);
        wr(3'd0, sh_dr | 8'h04);
        rd(3'd4, v); chk("R9 fall ack clears", v, 8'h00);
        set_mode(2, 4'd2);

        // R11 leaving edge mode drops the flag
        set_mode(5, 4'd6);
        pin_in[5] = 1'b1; wait_cyc(4);
        pin_in[5] = 1'b0; wait_cyc(4);
        rd(3'd4, v); chk("R11 set before exit", v, 8'h20);
        sh_alt[5] = 1'b0; wr(3'd2, sh_alt);
        wait_cyc(1);
        rd(3'd4, v); chk("R11 dropped on exit", v, 8'h00);
        chk("R11 R10 irq low", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule